// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading up to two descriptors from a page table in memory. A client offers a request with the virtual address, the table base, the current address-space identifier and a format-enable flag. The walker then reads the first-level descriptor over a valid/ready request channel and waits for the response. If that descriptor points to a second-level table, it reads a second-level descriptor as well. It decodes what it reads and presents one result. The result carries either a physical address with its page size and attribute bits, or a fault with a fault kind and the level at which the fault occurred.

The walker decodes the newer descriptor layout only. At the first level it maps 1MB sections and 16MB supersections. At the second level it maps 64KB large pages and 4KB extended small pages. The attribute bits are copied out as they are and are not interpreted: execute-never, not-global, shareable, non-secure, domain, the three access-permission bits and the memory-type bits. The client checks permissions, interprets memory types and caches the translation. The result is held until the client acknowledges it. Only after that does the walker accept a new request.

Top module: `ptw_walker`

## Requirements
- R1: A request is accepted only on a cycle with `req_valid` and `req_ready` both high. `req_ready` is high only while the walker is idle. The result is presented with `res_valid` and holds every result output stable until a cycle with `res_ready` high. The walker is idle on the next cycle and does not accept a request during the acknowledge cycle itself. The inputs `req_va`, `req_ttb`, `new_fmt_en` and `cur_asid` are captured at acceptance, so later changes to them do not affect the walk.
- R2: The first memory read uses the address {ttb[31:14], va[31:20], 2'b00}. `mem_req_valid` and `mem_req_addr` stay stable until `mem_req_ready` is high. A response on `mem_rsp_valid`/`mem_rsp_data` is taken only after that request handshake.
- R3: A first-level descriptor with bits [1:0] = 00 or 11 ends the walk after one read. The result is a translation fault: `res_fault_kind` = 1 and `res_fault_l2` = 0. On any fault, `res_pa`, `res_size`, all attribute outputs and `res_asid` are zero.
- R4: A first-level descriptor with bits [1:0] = 10 and bit 18 = 0 is a 1MB section. Its result is pa = {d[31:20], va[19:0]} with `res_size` = 2. The attribute bits are B=d[2], C=d[3], XN=d[4], domain=d[8:5], AP[1:0]=d[11:10], TEX=d[14:12], APX=d[15], S=d[16], nG=d[17] and NS=d[19]. `res_ap` is {APX, AP[1:0]}.
- R5: A first-level descriptor with bits [1:0] = 10 and bit 18 = 1 is a 16MB supersection. Its result is pa = {d[31:24], va[23:0]} with `res_size` = 3. It uses the same attribute positions as R4, except that the domain is reported as 0.
- R6: A first-level descriptor with bits [1:0] = 01 triggers a second read at {d[31:10], va[19:12], 2'b00}. A page result reached this way takes its domain from d[8:5] and its NS bit from d[3] of this first-level descriptor.
- R7: A second-level descriptor with bits [1:0] = 00 gives a translation fault with `res_fault_kind` = 1 and `res_fault_l2` = 1.
- R8: A second-level descriptor with bits [1:0] = 01 is a 64KB large page. Its result is pa = {d[31:16], va[15:0]} with `res_size` = 1, B=d[2], C=d[3], AP[1:0]=d[5:4], APX=d[9], S=d[10], nG=d[11], TEX=d[14:12] and XN=d[15].
- R9: A second-level descriptor with bits [1:0] = 1x is a 4KB small page. Its result is pa = {d[31:12], va[11:0]} with `res_size` = 0, XN=d[0], B=d[2], C=d[3], AP[1:0]=d[5:4], TEX=d[8:6], APX=d[9], S=d[10] and nG=d[11].
- R10: `res_asid` equals the `cur_asid` captured at acceptance when the result has nG = 1. It is zero when nG = 0.
- R11: If `new_fmt_en` is low at acceptance, the walker makes no memory read. It reports an unsupported-format fault with `res_fault_kind` = 2 and `res_fault_l2` = 0 on the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_va | input | 32 | Virtual address to translate |
| req_ttb | input | 32 | First-level table base (bits 31:14 used) |
| new_fmt_en | input | 1 | Newer descriptor layout enabled |
| cur_asid | input | ASID_W | Current address-space identifier |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Descriptor data returned |
| mem_rsp_data | input | 32 | Descriptor word |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Client acknowledges the result |
| res_pa | output | 32 | Physical address |
| res_size | output | 2 | 0 = 4KB, 1 = 64KB, 2 = 1MB, 3 = 16MB |
| res_fault | output | 1 | Result is a fault |
| res_fault_kind | output | 2 | 0 = none, 1 = translation, 2 = unsupported format |
| res_fault_l2 | output | 1 | Fault raised at the second level |
| res_xn | output | 1 | Execute-never |
| res_ng | output | 1 | Not-global (process-specific) |
| res_s | output | 1 | Shareable |
| res_ns | output | 1 | Non-secure mapping |
| res_domain | output | 4 | Domain number |
| res_ap | output | 3 | {APX, AP[1:0]} |
| res_tex | output | 3 | Memory type extension bits |
| res_c | output | 1 | Cacheable bit |
| res_b | output | 1 | Bufferable bit |
| res_asid | output | ASID_W | Tag for process-specific results, else zero |

## Verification
The acknowledge of a finished result and a new request can fall in the same cycle. The bench provokes this by raising `res_ready` together with `req_valid` carrying the next walk's inputs. It then judges that `req_ready` was low in that cycle and high in the following one, and that the next result belongs only to the request offered afterwards. A second overlap is the arrival of fresh input values while a walk is in flight. The bench scrambles the request inputs immediately after acceptance and still expects addresses and results computed from the captured values. It also sweeps every first- and second-level type code, with varied memory stalls and response latencies.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int VA_W   = 32;
    localparam int DESC_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_L1_REQ  = 3'd1,
        ST_L1_WAIT = 3'd2,
        ST_L2_REQ  = 3'd3,
        ST_L2_WAIT = 3'd4,
        ST_DONE    = 3'd5
    } walk_state_e;

    typedef enum logic [1:0] {
        SZ_4K   = 2'd0,
        SZ_64K  = 2'd1,
        SZ_1M   = 2'd2,
        SZ_16M  = 2'd3
    } page_size_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_XLATE  = 2'd1,
        FLT_FORMAT = 2'd2
    } fault_e;

    typedef enum logic [1:0] {
        L1K_FAULT = 2'd0,
        L1K_TABLE = 2'd1,
        L1K_BLOCK = 2'd2
    } l1_kind_e;

    typedef struct packed {
        logic       xn;
        logic       ng;
        logic       s;
        logic       ns;
        logic [3:0] domain;
        logic [2:0] ap;
        logic [2:0] tex;
        logic       c;
        logic       b;
    } attr_t;

    typedef struct packed {
        logic [VA_W-1:0] pa;
        page_size_e      size;
        fault_e          fault;
        logic            fault_l2;
        attr_t           attr;
    } walk_res_t;

    function automatic logic [VA_W-1:0] l1_fetch_addr(
        input logic [17:0] base_hi,
        input logic [VA_W-1:0] va
    );
        return {base_hi, va[31:20], 2'b00};
    endfunction

    function automatic logic [VA_W-1:0] l2_fetch_addr(
        input logic [21:0] tbl_base,
        input logic [VA_W-1:0] va
    );
        return {tbl_base, va[19:12], 2'b00};
    endfunction

    function automatic walk_res_t fault_result(input fault_e kind, input logic at_l2);
        walk_res_t r;
        r          = '0;
        r.fault    = kind;
        r.fault_l2 = at_l2;
        return r;
    endfunction

endpackage

// File: rtl/ptw_l1_decode.sv
module ptw_l1_decode
    import ptw_pkg::*;
(
    input  logic [DESC_W-1:0] desc,
    input  logic [VA_W-1:0]   va,
    output l1_kind_e          kind,
    output walk_res_t         res,
    output logic [21:0]       tbl_base,
    output logic [3:0]        tbl_domain,
    output logic              tbl_ns
);

    logic unused_pbit;
    assign unused_pbit = desc[9];

    assign tbl_base   = desc[31:10];
    assign tbl_domain = desc[8:5];
    assign tbl_ns     = desc[3];

    always_comb begin
        kind = L1K_FAULT;
        res  = fault_result(FLT_XLATE, 1'b0);
        case (desc[1:0])
            2'b01: begin
                kind = L1K_TABLE;
            end
            2'b10: begin
                kind            = L1K_BLOCK;
                res             = '0;
                res.attr.b      = desc[2];
                res.attr.c      = desc[3];
                res.attr.xn     = desc[4];
                res.attr.ap     = {desc[15], desc[11:10]};
                res.attr.tex    = desc[14:12];
                res.attr.s      = desc[16];
                res.attr.ng     = desc[17];
                res.attr.ns     = desc[19];
                if (desc[18]) begin
                    res.size        = SZ_16M;
                    res.pa          = {desc[31:24], va[23:0]};
                    res.attr.domain = 4'd0;
                end else begin
                    res.size        = SZ_1M;
                    res.pa          = {desc[31:20], va[19:0]};
                    res.attr.domain = desc[8:5];
                end
            end
            default: begin
                kind = L1K_FAULT;
            end
        endcase
    end

endmodule

// File: rtl/ptw_l2_decode.sv
module ptw_l2_decode
    import ptw_pkg::*;
(
    input  logic [DESC_W-1:0] desc,
    input  logic [VA_W-1:0]   va,
    input  logic [3:0]        domain_in,
    input  logic              ns_in,
    output walk_res_t         res
);

    always_comb begin
        res             = '0;
        res.attr.domain = domain_in;
        res.attr.ns     = ns_in;
        res.attr.b      = desc[2];
        res.attr.c      = desc[3];
        res.attr.ap     = {desc[9], desc[5:4]};
        res.attr.s      = desc[10];
        res.attr.ng     = desc[11];
        case (desc[1:0])
            2'b00: begin
                res = fault_result(FLT_XLATE, 1'b1);
            end
            2'b01: begin
                res.size     = SZ_64K;
                res.pa       = {desc[31:16], va[15:0]};
                res.attr.tex = desc[14:12];
                res.attr.xn  = desc[15];
            end
            default: begin
                res.size     = SZ_4K;
                res.pa       = {desc[31:12], va[11:0]};
                res.attr.tex = desc[8:6];
                res.attr.xn  = desc[0];
            end
        endcase
    end

endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        fmt_en,
    input  logic        mem_req_ready,
    input  logic        mem_rsp_valid,
    input  l1_kind_e    l1_kind,
    input  logic        res_ready,
    output walk_state_e state,
    output logic        req_ready,
    output logic        mem_req_valid,
    output logic        res_valid,
    output logic        accept,
    output logic        fmt_reject,
    output logic        l1_take,
    output logic        l2_take
);

    walk_state_e state_q, state_d;

    assign state         = state_q;
    assign req_ready     = (state_q == ST_IDLE);
    assign mem_req_valid = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
    assign res_valid     = (state_q == ST_DONE);
    assign accept        = req_ready && req_valid;
    assign fmt_reject    = accept && !fmt_en;
    assign l1_take       = (state_q == ST_L1_WAIT) && mem_rsp_valid;
    assign l2_take       = (state_q == ST_L2_WAIT) && mem_rsp_valid;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:    if (req_valid)     state_d = fmt_en ? ST_L1_REQ : ST_DONE;
            ST_L1_REQ:  if (mem_req_ready) state_d = ST_L1_WAIT;
            ST_L1_WAIT: if (mem_rsp_valid) state_d = (l1_kind == L1K_TABLE) ? ST_L2_REQ : ST_DONE;
            ST_L2_REQ:  if (mem_req_ready) state_d = ST_L2_WAIT;
            ST_L2_WAIT: if (mem_rsp_valid) state_d = ST_DONE;
            ST_DONE:    if (res_ready)     state_d = ST_IDLE;
            default:                       state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // R2: an outstanding descriptor read is never withdrawn
    a_r2_req_held: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid);

    // R1: after an acknowledge the walker is idle
    a_r1_ack_to_idle: assert property (@(posedge clk) disable iff (rst)
        res_valid && res_ready |=> req_ready && !res_valid);

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int ASID_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_va,
    input  logic [31:0]       req_ttb,
    input  logic              new_fmt_en,
    input  logic [ASID_W-1:0] cur_asid,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [31:0]       mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data,
    output logic              res_valid,
    input  logic              res_ready,
    output logic [31:0]       res_pa,
    output logic [1:0]        res_size,
    output logic              res_fault,
    output logic [1:0]        res_fault_kind,
    output logic              res_fault_l2,
    output logic              res_xn,
    output logic              res_ng,
    output logic              res_s,
    output logic              res_ns,
    output logic [3:0]        res_domain,
    output logic [2:0]        res_ap,
    output logic [2:0]        res_tex,
    output logic              res_c,
    output logic              res_b,
    output logic [ASID_W-1:0] res_asid
);

    walk_state_e       state;
    logic              accept, fmt_reject, l1_take, l2_take;
    l1_kind_e          l1_kind;
    walk_res_t         l1_res, l2_res, res_q;
    logic [21:0]       l1_tbl_base;
    logic [3:0]        l1_tbl_dom;
    logic              l1_tbl_ns;

    logic [VA_W-1:0]   va_q;
    logic [17:0]       base_hi_q;
    logic [ASID_W-1:0] asid_q;
    logic [21:0]       tbl_base_q;
    logic [3:0]        tbl_dom_q;
    logic              tbl_ns_q;

    ptw_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .fmt_en        (new_fmt_en),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .l1_kind       (l1_kind),
        .res_ready     (res_ready),
        .state         (state),
        .req_ready     (req_ready),
        .mem_req_valid (mem_req_valid),
        .res_valid     (res_valid),
        .accept        (accept),
        .fmt_reject    (fmt_reject),
        .l1_take       (l1_take),
        .l2_take       (l2_take)
    );

    ptw_l1_decode u_l1 (
        .desc       (mem_rsp_data),
        .va         (va_q),
        .kind       (l1_kind),
        .res        (l1_res),
        .tbl_base   (l1_tbl_base),
        .tbl_domain (l1_tbl_dom),
        .tbl_ns     (l1_tbl_ns)
    );

    ptw_l2_decode u_l2 (
        .desc      (mem_rsp_data),
        .va        (va_q),
        .domain_in (tbl_dom_q),
        .ns_in     (tbl_ns_q),
        .res       (l2_res)
    );

    // Request capture: later input changes do not reach the walk
    always_ff @(posedge clk) begin
        if (rst) begin
            va_q      <= '0;
            base_hi_q <= '0;
            asid_q    <= '0;
        end else if (accept) begin
            va_q      <= req_va;
            base_hi_q <= req_ttb[31:14];
            asid_q    <= cur_asid;
        end
    end

    // Coarse table pointer and inherited attributes
    always_ff @(posedge clk) begin
        if (rst) begin
            tbl_base_q <= '0;
            tbl_dom_q  <= '0;
            tbl_ns_q   <= 1'b0;
        end else if (l1_take && l1_kind == L1K_TABLE) begin
            tbl_base_q <= l1_tbl_base;
            tbl_dom_q  <= l1_tbl_dom;
            tbl_ns_q   <= l1_tbl_ns;
        end
    end

    // Result register, loaded only on entry to DONE
    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else if (fmt_reject) begin
            res_q <= fault_result(FLT_FORMAT, 1'b0);
        end else if (l1_take && l1_kind != L1K_TABLE) begin
            res_q <= l1_res;
        end else if (l2_take) begin
            res_q <= l2_res;
        end
    end

    assign mem_req_addr = (state == ST_L2_REQ) ? l2_fetch_addr(tbl_base_q, va_q)
                                               : l1_fetch_addr(base_hi_q, va_q);

    assign res_pa         = res_q.pa;
    assign res_size       = res_q.size;
    assign res_fault      = (res_q.fault != FLT_NONE);
    assign res_fault_kind = res_q.fault;
    assign res_fault_l2   = res_q.fault_l2;
    assign res_xn         = res_q.attr.xn;
    assign res_ng         = res_q.attr.ng;
    assign res_s          = res_q.attr.s;
    assign res_ns         = res_q.attr.ns;
    assign res_domain     = res_q.attr.domain;
    assign res_ap         = res_q.attr.ap;
    assign res_tex        = res_q.attr.tex;
    assign res_c          = res_q.attr.c;
    assign res_b          = res_q.attr.b;
    assign res_asid       = res_q.attr.ng ? asid_q : '0;

    // R1: result held until acknowledged
    a_r1_result_stable: assert property (@(posedge clk) disable iff (rst)
        res_valid && !res_ready |=> res_valid && $stable(res_pa) && $stable(res_size)
            && $stable(res_fault_kind) && $stable(res_asid));

    // R2: read address unchanged while the request waits
    a_r2_addr_stable: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> $stable(mem_req_addr));

    // R3: faults carry no address or attributes
    a_r3_fault_clean: assert property (@(posedge clk) disable iff (rst)
        res_valid && res_fault |-> res_pa == '0 && res_domain == '0 && res_ap == '0 && res_asid == '0);

    // R10: global results carry no ASID tag
    a_r10_global_untagged: assert property (@(posedge clk) disable iff (rst)
        res_valid && !res_ng |-> res_asid == '0);

    // R11: disabled format faults at once without a read
    a_r11_format_fault: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && !new_fmt_en |=> res_valid && res_fault_kind == 2'd2 && !mem_req_valid);

endmodule

// File: tb/ptw_walker_bench.sv
`timescale 1ns/1ps
module ptw_walker_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready, new_fmt_en;
    logic [31:0] req_va, req_ttb;
    logic [7:0]  cur_asid;
    logic        mem_req_valid, mem_req_ready, mem_rsp_valid;
    logic [31:0] mem_req_addr, mem_rsp_data;
    logic        res_valid, res_ready;
    logic [31:0] res_pa;
    logic [1:0]  res_size, res_fault_kind;
    logic        res_fault, res_fault_l2, res_xn, res_ng, res_s, res_ns, res_c, res_b;
    logic [3:0]  res_domain;
    logic [2:0]  res_ap, res_tex;
    logic [7:0]  res_asid;

    int n_tests = 0;
    int n_fail  = 0;
    int n_reads = 0;

    always #5 clk = ~clk;

    ptw_walker #(.ASID_W(8)) u_ptw_walker (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va), .req_ttb(req_ttb),
        .new_fmt_en(new_fmt_en), .cur_asid(cur_asid),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .res_valid(res_valid), .res_ready(res_ready), .res_pa(res_pa), .res_size(res_size),
        .res_fault(res_fault), .res_fault_kind(res_fault_kind), .res_fault_l2(res_fault_l2),
        .res_xn(res_xn), .res_ng(res_ng), .res_s(res_s), .res_ns(res_ns), .res_domain(res_domain),
        .res_ap(res_ap), .res_tex(res_tex), .res_c(res_c), .res_b(res_b), .res_asid(res_asid)
    );

    always @(posedge clk) if (!rst && mem_req_valid && mem_req_ready) n_reads++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // expected result computed from the requirement text
    logic [31:0] e_pa, e_l1a, e_l2a;
    logic [20:0] e_attr;
    logic [7:0]  e_asid;
    int          e_reads;
    string       e_tag;

    task automatic model(input logic [31:0] va, ttb, l1d, l2d, input logic fmt, input logic [7:0] asid);
        logic [1:0] sz, kind;
        logic l2f, xn, ng, s, ns, c, b;
        logic [3:0] dom;
        logic [2:0] ap, tex;
        logic [31:0] mask;
        {sz, kind, l2f, xn, ng, s, ns, c, b, dom, ap, tex} = '0;
        e_pa  = 0;
        e_l1a = (ttb & 32'hFFFF_C000) | ((va >> 18) & 32'h0000_3FFC);
        e_l2a = (l1d & 32'hFFFF_FC00) | ((va >> 10) & 32'h0000_03FC);
        if (!fmt) begin
            kind = 2; e_reads = 0; e_tag = "R11";
        end else if (l1d[1:0] == 2'b00 || l1d[1:0] == 2'b11) begin
            kind = 1; e_reads = 1; e_tag = "R3";
        end else if (l1d[1:0] == 2'b10) begin
            e_reads = 1;
            b = l1d[2]; c = l1d[3]; xn = l1d[4]; ap = {l1d[15], l1d[11:10]};
            tex = l1d[14:12]; s = l1d[16]; ng = l1d[17]; ns = l1d[19];
            if (l1d[18]) begin
                mask = 32'h00FF_FFFF; sz = 3; dom = 0; e_tag = "R5";
            end else begin
                mask = 32'h000F_FFFF; sz = 2; dom = l1d[8:5]; e_tag = "R4";
            end
            e_pa = (l1d & ~mask) | (va & mask);
        end else begin
            e_reads = 2;
            if (l2d[1:0] == 2'b00) begin
                kind = 1; l2f = 1; e_tag = "R7";
            end else begin
                dom = l1d[8:5]; ns = l1d[3];
                b = l2d[2]; c = l2d[3]; ap = {l2d[9], l2d[5:4]}; s = l2d[10]; ng = l2d[11];
                if (l2d[1:0] == 2'b01) begin
                    mask = 32'h0000_FFFF; sz = 1; tex = l2d[14:12]; xn = l2d[15]; e_tag = "R8";
                end else begin
                    mask = 32'h0000_0FFF; sz = 0; tex = l2d[8:6]; xn = l2d[0]; e_tag = "R9";
                end
                e_pa = (l2d & ~mask) | (va & mask);
            end
        end
        e_attr = {sz, kind, l2f, xn, ng, s, ns, dom, ap, tex, c, b};
        e_asid = ng ? asid : 8'h00;
    endtask

    function automatic logic [20:0] got_attr();
        return {res_size, res_fault_kind, res_fault_l2, res_xn, res_ng, res_s, res_ns,
                res_domain, res_ap, res_tex, res_c, res_b};
    endfunction

    task automatic serve(input logic [31:0] addr, input logic [31:0] data, input int stall,
                         input int lat, input string tag);
        int guard = 0;
        while (!mem_req_valid && guard < 20) begin @(negedge clk); guard++; end
        chk({tag, " read issued"}, {31'd0, mem_req_valid}, 32'd1);
        for (int i = 0; i < stall; i++) begin
            chk({tag, " addr while stalled"}, mem_req_addr, addr);
            @(negedge clk);
            chk("R2 request held", {31'd0, mem_req_valid}, 32'd1);
        end
        mem_req_ready = 1'b1;
        chk({tag, " read address"}, mem_req_addr, addr);
        @(negedge clk);
        mem_req_ready = 1'b0;
        for (int i = 0; i < lat; i++) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = data;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = ~data;
    endtask

    // one complete walk; overlap raises the next request during the acknowledge
    task automatic walk(input logic [31:0] va, ttb, l1d, l2d, input logic fmt,
                        input logic [7:0] asid, input int stall, input int lat, input logic overlap);
        int start, guard;
        logic [20:0] held_attr;
        logic [31:0] held_pa;
        model(va, ttb, l1d, l2d, fmt, asid);
        start = n_reads;
        @(negedge clk);
        req_valid = 1'b1; req_va = va; req_ttb = ttb; new_fmt_en = fmt; cur_asid = asid;
        chk("R1 idle accepts", {31'd0, req_ready}, 32'd1);
        @(negedge clk);
        req_valid = 1'b0; req_va = ~va; req_ttb = ~ttb; new_fmt_en = ~fmt; cur_asid = ~asid;
        if (e_reads == 0) chk("R11 result next cycle", {31'd0, res_valid}, 32'd1);
        if (e_reads >= 1) serve(e_l1a, l1d, stall, lat, "R2");
        if (e_reads == 2) serve(e_l2a, l2d, stall, lat, "R6");
        guard = 0;
        while (!res_valid && guard < 20) begin @(negedge clk); guard++; end
        chk({e_tag, " valid"}, {31'd0, res_valid}, 32'd1);
        chk({e_tag, " pa"}, res_pa, e_pa);
        chk({e_tag, " attributes"}, {11'd0, got_attr()}, {11'd0, e_attr});
        chk("R10 asid tag", {24'd0, res_asid}, {24'd0, e_asid});
        held_attr = got_attr(); held_pa = res_pa;
        @(negedge clk);
        chk("R1 held valid", {31'd0, res_valid}, 32'd1);
        chk("R1 held pa", res_pa, held_pa);
        chk("R1 held attributes", {11'd0, got_attr()}, {11'd0, held_attr});
        res_ready = 1'b1;
        if (overlap) begin
            req_valid = 1'b1;
            chk("R1 no accept while done", {31'd0, req_ready}, 32'd0);
        end
        @(negedge clk);
        res_ready = 1'b0;
        chk("R1 released", {31'd0, res_valid}, 32'd0);
        if (overlap) begin
            chk("R1 idle after ack", {31'd0, req_ready}, 32'd1);
            req_valid = 1'b0;
        end
        chk({e_tag, " read count"}, n_reads - start, e_reads);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] pat, va, l1d, l2d;
        int k = 0;
        rst = 1'b1; req_valid = 0; req_va = 0; req_ttb = 0; new_fmt_en = 0; cur_asid = 0;
        mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0; res_ready = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset idle", {31'd0, req_ready}, 32'd1);
        chk("R1 reset no result", {31'd0, res_valid}, 32'd0);
        chk("R2 reset no read", {31'd0, mem_req_valid}, 32'd0);

        for (int t1 = 0; t1 < 4; t1++)
            for (int b18 = 0; b18 < 2; b18++)
                for (int t2 = 0; t2 < 4; t2++)
                    for (int p = 0; p < 3; p++) begin
                        if (t1 != 1 && t2 != 0) continue;
                        k++;
                        pat = (32'h9E37_79B9 * k) ^ (32'h6B8B_4567 >> p) ^ (32'h0002_0800 * (p & 1));
                        va  = (32'hC0DE_1234 * (k + 7)) ^ {16'h0, pat[31:16]};
                        l1d = {pat[31:19], b18[0], pat[17:2], t1[1:0]};
                        l2d = {~pat[15:0], pat[31:18], t2[1:0]};
                        walk(va, pat ^ 32'h5A5A_0000, l1d, l2d, 1'b1, pat[7:0] | 8'h01,
                             k % 3, k % 2, (k % 4) == 0);
                    end

        // R11: format disabled, whatever the descriptors would hold
        for (int i = 0; i < 4; i++)
            walk(32'h1357_9BDF + i, 32'hFEDC_0000, 32'h0000_0C12, 32'h0000_0802, 1'b0,
                 8'hA0 + i[7:0], 0, 0, i[0]);
        // R9 and R10: small page, nG set, XN from bit 0, in back-to-back overlap
        walk(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FC01, 32'hFFFF_FFFF, 1'b1, 8'h5C, 2, 1, 1'b1);
        walk(32'h0000_0000, 32'h0000_0000, 32'h0000_0001, 32'h0000_0802, 1'b1, 8'h3E, 0, 0, 1'b1);
        // R4: section at the top of memory, R5: supersection with domain bits set
        walk(32'h89AB_CDEF, 32'h0001_C000, 32'hFFF2_FDE2, 32'h0, 1'b1, 8'h11, 1, 3, 1'b0);
        walk(32'h89AB_CDEF, 32'h0001_C000, 32'hAB06_01E2, 32'h0, 1'b1, 8'h22, 0, 2, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule